// File: doc/BRIEF.md
# Peripheral Register Bit-Field Accessor

This block carries out single bit-field operations on a bank of 32-bit peripheral registers for a small coprocessor. An instruction supplies a register address counted in 32-bit words, a high and a low bit index, a write flag and an 8-bit immediate. The block acts as master on a simple request/grant register bus and performs only masked field operations. Full-word transfers are not among its functions.

A read fetches the addressed word and returns bits high..low. The field is shifted down to bit 0 and zero-extended, then written back to the coprocessor's R0 register through a write-enable and data pair. A write is a fixed read-modify-write sequence. The block reads the word, replaces bits high..low with the immediate and writes the word back, so all other bits are kept. Every accepted instruction ends with a one-cycle done pulse. The coprocessor has lower priority on the bus than the main processors, so any bus transfer may be held off by a withheld grant. Each such cycle lengthens the operation by exactly one cycle.

Top module: `field_access_unit`

## Requirements
- R1: After reset, `done_o`, `r0_we_o` and `bus_req_o` are low.
- R2: A read puts the register address on `bus_addr_o` unchanged, in word units. It returns bits hi..lo of the word in `r0_data_o`, shifted down to bit 0 with zeros above the field. For example, bits 7:4 of 0x123456A5 give 0x000A.
- R3: Without stalls, a read raises `done_o` and `r0_we_o` together in the 4th cycle after the cycle in which `start_i` was sampled. `done_o` lasts exactly one cycle.
- R4: A write performs exactly one bus read and then exactly one bus write of the same word. In the written word, bits hi..lo hold the immediate zero-extended to the field width, and immediate bits above the field width are dropped. Every bit outside hi..lo keeps its read value.
- R5: Without stalls, a write raises `done_o` in the 8th cycle after the start cycle (`WR_CYCLES`, which must be at least 6), and `r0_we_o` stays low.
- R6: While `bus_gnt_i` is low, a pending transfer holds `bus_req_o`, `bus_we_o`, `bus_addr_o` and `bus_wdata_o` steady. Each stalled cycle delays `done_o` by one cycle.
- R7: When hi < lo, the access is a no-op. No bus request is made, `r0_we_o` stays low, and `done_o` pulses in the 2nd cycle after the start cycle.
- R8: A read wider than 16 bits (hi-lo+1 > 16) is a no-op handled as in R7, while a read of exactly 16 bits is performed. A write field may be any width up to the full 32 bits.
- R9: `start_i` is ignored from the cycle after acceptance up to and including the done cycle. It starts no second access and produces no extra done pulse.
- R10: Fields at the extremes of the word are handled: bits 31:16, a single bit 31:31 and a single bit 0:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Issue an instruction (sampled only when idle) |
| write_i | input | 1 | 1 = field write, 0 = field read |
| addr_i | input | 8 | Register address in 32-bit words |
| hi_i | input | 5 | Field high bit index |
| lo_i | input | 5 | Field low bit index |
| imm_i | input | 8 | Immediate for a field write |
| bus_req_o | output | 1 | Bus transfer request |
| bus_we_o | output | 1 | Bus transfer is a write |
| bus_addr_o | output | 8 | Bus word address |
| bus_wdata_o | output | 32 | Bus write data |
| bus_rdata_i | input | 32 | Bus read data, valid in the granted cycle |
| bus_gnt_i | input | 1 | Grant; the transfer completes in a cycle with request and grant |
| r0_we_o | output | 1 | Write strobe for R0 |
| r0_data_o | output | 16 | Value for R0 |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The hardest situation to reach is a grant withheld during the read half of a write, followed by a granted write half. The stall must leave the merge intact and stretch the total by exactly the stalled cycles. The bench bus model keeps a budget of grant refusals, which it spends on the next requested cycles. Setting the budget before a write aims the stall at the read phase alone. A second corner is a new `start_i` raised in the middle of an access with different fields. The bench pokes it mid-read and then watches both for a stray done pulse and for changes to the register the poke pointed at.

// File: rtl/fa_pkg.sv
package fa_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_RD_BUS,
    ST_FIT,
    ST_WR_BUS,
    ST_HOLD,
    ST_FINISH
  } fa_state_e;

  // cycles from acceptance to done for an unstalled read
  localparam int unsigned FA_RD_CYCLES = 4;
  // cycles from acceptance to done for a rejected field
  localparam int unsigned FA_NOP_CYCLES = 2;
endpackage

// File: rtl/fa_field_mask.sv
module fa_field_mask #(
  parameter int unsigned DW = 32,
  parameter int unsigned RW = 16,
  localparam int unsigned XW = $clog2(DW)
) (
  input  logic [XW-1:0] hi_i,
  input  logic [XW-1:0] lo_i,
  input  logic          write_i,
  output logic [DW-1:0] mask_o,
  output logic          valid_o
);
  logic [XW:0] width;

  for (genvar b = 0; b < DW; b++) begin : g_bit
    assign mask_o[b] = (XW'(b) >= lo_i) && (XW'(b) <= hi_i);
  end

  assign width   = {1'b0, hi_i} - {1'b0, lo_i} + (XW+1)'(1);
  assign valid_o = (hi_i >= lo_i) && (write_i || (width <= (XW+1)'(RW)));
endmodule

// File: rtl/fa_field_alu.sv
module fa_field_alu #(
  parameter int unsigned DW = 32,
  parameter int unsigned RW = 16,
  parameter int unsigned MW = 8,
  localparam int unsigned XW = $clog2(DW)
) (
  input  logic [DW-1:0] word_i,
  input  logic [DW-1:0] mask_i,
  input  logic [XW-1:0] lo_i,
  input  logic [MW-1:0] imm_i,
  output logic [RW-1:0] field_o,
  output logic [DW-1:0] merged_o
);
  // extract: isolate then align to bit 0
  assign field_o  = RW'((word_i & mask_i) >> lo_i);
  // merge: keep outside bits, drop immediate bits past the field
  assign merged_o = (word_i & ~mask_i) | ((DW'(imm_i) << lo_i) & mask_i);
endmodule

// File: rtl/fa_seq.sv
module fa_seq import fa_pkg::*; #(
  parameter int unsigned WR_CYCLES = 8,
  localparam int unsigned HOLD_LEN = WR_CYCLES - 5,
  localparam int unsigned HW = (HOLD_LEN > 1) ? $clog2(HOLD_LEN) : 1
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      start_i,
  input  logic      write_i,
  input  logic      valid_i,
  input  logic      gnt_i,
  output fa_state_e state_o,
  output logic      accept_o
);
  fa_state_e state_q, state_d;
  logic [HW-1:0] hold_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (start_i) state_d = ST_SETUP;
      ST_SETUP:  state_d = valid_i ? ST_RD_BUS : ST_FINISH;
      ST_RD_BUS: if (gnt_i) state_d = ST_FIT;
      ST_FIT:    state_d = write_i ? ST_WR_BUS : ST_FINISH;
      ST_WR_BUS: if (gnt_i) state_d = ST_HOLD;
      ST_HOLD:   if (hold_q == '0) state_d = ST_FINISH;
      ST_FINISH: state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      hold_q  <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_WR_BUS && gnt_i) hold_q <= HW'(HOLD_LEN - 1);
      else if (state_q == ST_HOLD && hold_q != '0) hold_q <= hold_q - HW'(1);
    end
  end

  assign state_o  = state_q;
  assign accept_o = (state_q == ST_IDLE) && start_i;
endmodule

// File: rtl/field_access_unit.sv
module field_access_unit import fa_pkg::*; #(
  parameter int unsigned DW = 32,
  parameter int unsigned AW = 8,
  parameter int unsigned RW = 16,
  parameter int unsigned MW = 8,
  parameter int unsigned WR_CYCLES = 8,
  localparam int unsigned XW = $clog2(DW)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          write_i,
  input  logic [AW-1:0] addr_i,
  input  logic [XW-1:0] hi_i,
  input  logic [XW-1:0] lo_i,
  input  logic [MW-1:0] imm_i,
  output logic          bus_req_o,
  output logic          bus_we_o,
  output logic [AW-1:0] bus_addr_o,
  output logic [DW-1:0] bus_wdata_o,
  input  logic [DW-1:0] bus_rdata_i,
  input  logic          bus_gnt_i,
  output logic          r0_we_o,
  output logic [RW-1:0] r0_data_o,
  output logic          done_o
);
  fa_state_e     state;
  logic          accept;
  logic          wr_q;
  logic [AW-1:0] addr_q;
  logic [XW-1:0] hi_q, lo_q;
  logic [MW-1:0] imm_q;
  logic [DW-1:0] word_q;
  logic [RW-1:0] r0_q;
  logic [DW-1:0] mask, merged;
  logic [RW-1:0] field;
  logic          valid;

  fa_field_mask #(.DW(DW), .RW(RW)) u_mask (
    .hi_i    (hi_q),
    .lo_i    (lo_q),
    .write_i (wr_q),
    .mask_o  (mask),
    .valid_o (valid)
  );

  fa_field_alu #(.DW(DW), .RW(RW), .MW(MW)) u_alu (
    .word_i   (word_q),
    .mask_i   (mask),
    .lo_i     (lo_q),
    .imm_i    (imm_q),
    .field_o  (field),
    .merged_o (merged)
  );

  fa_seq #(.WR_CYCLES(WR_CYCLES)) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .write_i  (wr_q),
    .valid_i  (valid),
    .gnt_i    (bus_gnt_i),
    .state_o  (state),
    .accept_o (accept)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q   <= 1'b0;
      addr_q <= '0;
      hi_q   <= '0;
      lo_q   <= '0;
      imm_q  <= '0;
    end else if (accept) begin
      wr_q   <= write_i;
      addr_q <= addr_i;
      hi_q   <= hi_i;
      lo_q   <= lo_i;
      imm_q  <= imm_i;
    end
  end

  // one word register serves as read capture and merge result
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q <= '0;
      r0_q   <= '0;
    end else begin
      if (state == ST_RD_BUS && bus_gnt_i) word_q <= bus_rdata_i;
      if (state == ST_FIT) begin
        if (wr_q) word_q <= merged;
        else      r0_q   <= field;
      end
    end
  end

  assign bus_req_o   = (state == ST_RD_BUS) || (state == ST_WR_BUS);
  assign bus_we_o    = (state == ST_WR_BUS);
  assign bus_addr_o  = addr_q;
  assign bus_wdata_o = word_q;
  assign done_o      = (state == ST_FINISH);
  assign r0_we_o     = (state == ST_FINISH) && !wr_q && valid;
  assign r0_data_o   = r0_q;
endmodule

// File: rtl/fa_checker.sv
module fa_checker import fa_pkg::*; #(
  parameter int unsigned DW = 32,
  parameter int unsigned AW = 8,
  parameter int unsigned RW = 16,
  parameter int unsigned MW = 8,
  parameter int unsigned WR_CYCLES = 8,
  localparam int unsigned XW = $clog2(DW)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic          write_i,
  input logic [XW-1:0] hi_i,
  input logic [XW-1:0] lo_i,
  input logic [MW-1:0] imm_i,
  input logic          bus_req_o,
  input logic          bus_we_o,
  input logic [AW-1:0] bus_addr_o,
  input logic [DW-1:0] bus_wdata_o,
  input logic [DW-1:0] bus_rdata_i,
  input logic          bus_gnt_i,
  input logic          r0_we_o,
  input logic [RW-1:0] r0_data_o,
  input logic          done_o
);
  logic          busy_q, wr_q;
  logic [XW-1:0] hi_q, lo_q;
  logic [MW-1:0] imm_q;
  logic [15:0]   cyc_q, stall_q;
  logic [DW-1:0] rd_word_q, mask_c;
  logic          inv_c;
  int            exp_c;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0; wr_q <= 1'b0; hi_q <= '0; lo_q <= '0; imm_q <= '0;
      cyc_q <= '0; stall_q <= '0; rd_word_q <= '0;
    end else if (!busy_q) begin
      if (start_i) begin
        busy_q <= 1'b1; wr_q <= write_i; hi_q <= hi_i; lo_q <= lo_i;
        imm_q <= imm_i; cyc_q <= 16'd1; stall_q <= '0;
      end
    end else begin
      if (done_o) busy_q <= 1'b0;
      cyc_q <= cyc_q + 16'd1;
      if (bus_req_o && !bus_gnt_i) stall_q <= stall_q + 16'd1;
      if (bus_req_o && !bus_we_o && bus_gnt_i) rd_word_q <= bus_rdata_i;
    end
  end

  always_comb begin
    for (int b = 0; b < DW; b++) mask_c[b] = (b >= int'(lo_q)) && (b <= int'(hi_q));
    inv_c = (hi_q < lo_q) || (!wr_q && (int'(hi_q) - int'(lo_q) + 1 > int'(RW)));
    exp_c = inv_c ? int'(FA_NOP_CYCLES)
                  : (wr_q ? int'(WR_CYCLES) : int'(FA_RD_CYCLES)) + int'(stall_q);
  end

  // R1
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_q |-> (!bus_req_o && !done_o && !r0_we_o));
  // R3
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R3 R5 R6 R7
  latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (busy_q && int'(cyc_q) == exp_c));
  // R2
  r0_value_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    r0_we_o |-> (done_o && !wr_q && !inv_c && r0_data_o == RW'((rd_word_q & mask_c) >> lo_q)));
  // R4
  merge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && bus_we_o) |-> (((bus_wdata_o ^ rd_word_q) & ~mask_c) == '0 &&
      (bus_wdata_o & mask_c) == ((DW'(imm_q) << lo_q) & mask_c)));
  // R6
  stall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && !bus_gnt_i) |=> (bus_req_o && $stable(bus_we_o) &&
      $stable(bus_addr_o) && $stable(bus_wdata_o)));
  // R7 R8
  nop_no_bus_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && inv_c) |-> !bus_req_o);
endmodule

bind field_access_unit fa_checker #(
  .DW(DW), .AW(AW), .RW(RW), .MW(MW), .WR_CYCLES(WR_CYCLES)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .write_i     (write_i),
  .hi_i        (hi_i),
  .lo_i        (lo_i),
  .imm_i       (imm_i),
  .bus_req_o   (bus_req_o),
  .bus_we_o    (bus_we_o),
  .bus_addr_o  (bus_addr_o),
  .bus_wdata_o (bus_wdata_o),
  .bus_rdata_i (bus_rdata_i),
  .bus_gnt_i   (bus_gnt_i),
  .r0_we_o     (r0_we_o),
  .r0_data_o   (r0_data_o),
  .done_o      (done_o)
);

// File: tb/sim_field_access_unit.sv
module sim_field_access_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0, write_i = 1'b0;
  logic [7:0]  addr_i = '0;
  logic [4:0]  hi_i = '0, lo_i = '0;
  logic [7:0]  imm_i = '0;
  logic        bus_req_o, bus_we_o, bus_gnt_i, r0_we_o, done_o;
  logic [7:0]  bus_addr_o;
  logic [31:0] bus_wdata_o, bus_rdata_i;
  logic [15:0] r0_data_o;

  logic [31:0] mem [16];
  logic        ld_en = 1'b0;
  int          ld_idx = 0;
  logic [31:0] ld_val = '0;
  int          stall_set = 0, stall_used = 0;

  int tests = 0, fails = 0;
  int n_cyc, rd_g, wr_g;
  logic seen_r0we, req_seen, addr_bad, done_after;
  logic [15:0] r0v;

  always #(CLK_PERIOD/2) clk = ~clk;

  field_access_unit u0 (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .write_i(write_i),
    .addr_i(addr_i), .hi_i(hi_i), .lo_i(lo_i), .imm_i(imm_i),
    .bus_req_o(bus_req_o), .bus_we_o(bus_we_o), .bus_addr_o(bus_addr_o),
    .bus_wdata_o(bus_wdata_o), .bus_rdata_i(bus_rdata_i), .bus_gnt_i(bus_gnt_i),
    .r0_we_o(r0_we_o), .r0_data_o(r0_data_o), .done_o(done_o)
  );

  // bus model: combinational read, grant refused while budget remains
  assign bus_rdata_i = mem[bus_addr_o[3:0]];
  assign bus_gnt_i   = !(bus_req_o && (stall_set > stall_used));

  always @(posedge clk) begin
    if (bus_req_o && (stall_set > stall_used)) stall_used <= stall_used + 1;
    if (ld_en) mem[ld_idx[3:0]] <= ld_val;
    else if (bus_req_o && bus_we_o && bus_gnt_i) mem[bus_addr_o[3:0]] <= bus_wdata_o;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic load(input int idx, input logic [31:0] v);
    @(negedge clk); ld_en = 1'b1; ld_idx = idx; ld_val = v;
    @(negedge clk); ld_en = 1'b0;
  endtask

  task automatic run_op(input logic wr, input logic [7:0] a, input logic [4:0] h,
                        input logic [4:0] l, input logic [7:0] im, input bit poke);
    bit got = 0;
    n_cyc = 0; rd_g = 0; wr_g = 0; seen_r0we = 0; req_seen = 0; addr_bad = 0; r0v = '0;
    @(negedge clk);
    write_i = wr; addr_i = a; hi_i = h; lo_i = l; imm_i = im; start_i = 1'b1;
    while (!got && n_cyc < 64) begin
      @(negedge clk); n_cyc++;
      start_i = poke && (n_cyc == 2);
      if (poke && n_cyc == 2) begin
        write_i = 1'b1; addr_i = 8'd5; hi_i = 5'd15; lo_i = 5'd0; imm_i = 8'h00;
      end
      if (bus_req_o) begin
        req_seen = 1'b1;
        if (bus_addr_o != a) addr_bad = 1'b1;
        if (bus_gnt_i) begin
          if (bus_we_o) wr_g++;
          else rd_g++;
        end
      end
      if (done_o) begin
        got = 1; seen_r0we = r0_we_o; r0v = r0_data_o;
      end
    end
    @(negedge clk); done_after = done_o;
  endtask

  task automatic t_reset();
    chk("R1 done low", 32'(done_o), 32'd0);
    chk("R1 r0_we low", 32'(r0_we_o), 32'd0);
    chk("R1 req low", 32'(bus_req_o), 32'd0);
  endtask

  task automatic t_read_basic();
    load(3, 32'h1234_56A5);
    run_op(1'b0, 8'd3, 5'd7, 5'd4, 8'h00, 0);
    chk("R2 field 7:4", 32'(r0v), 32'h0000_000A);
    chk("R2 word address", 32'(addr_bad), 32'd0);
    chk("R3 latency", 32'(n_cyc), 32'd4);
    chk("R3 r0_we with done", 32'(seen_r0we), 32'd1);
    chk("R3 done one cycle", 32'(done_after), 32'd0);
    chk("R2 single read", 32'(rd_g * 16 + wr_g), 32'd16);
  endtask

  task automatic t_read_edges();
    load(5, 32'hBEEF_0000);
    load(6, 32'h0000_0001);
    run_op(1'b0, 8'd5, 5'd31, 5'd16, 8'h00, 0);
    chk("R10 field 31:16", 32'(r0v), 32'h0000_BEEF);
    run_op(1'b0, 8'd5, 5'd31, 5'd31, 8'h00, 0);
    chk("R10 bit 31", 32'(r0v), 32'h0000_0001);
    run_op(1'b0, 8'd6, 5'd0, 5'd0, 8'h00, 0);
    chk("R10 bit 0", 32'(r0v), 32'h0000_0001);
    run_op(1'b0, 8'd3, 5'd19, 5'd4, 8'h00, 0);
    chk("R8 16-bit read value", 32'(r0v), 32'h0000_456A);
    chk("R8 16-bit read latency", 32'(n_cyc), 32'd4);
  endtask

  task automatic t_write_basic();
    load(7, 32'hFFFF_FFFF);
    run_op(1'b1, 8'd7, 5'd11, 5'd8, 8'h35, 0);
    chk("R4 merged word", mem[7], 32'hFFFF_F5FF);
    chk("R4 one read one write", 32'(rd_g * 16 + wr_g), 32'd17);
    chk("R5 latency", 32'(n_cyc), 32'd8);
    chk("R5 no r0 write", 32'(seen_r0we), 32'd0);
    load(9, 32'h0000_0000);
    run_op(1'b1, 8'd9, 5'd15, 5'd8, 8'hC3, 0);
    chk("R4 8-bit field", mem[9], 32'h0000_C300);
  endtask

  task automatic t_write_wide();
    load(8, 32'hDEAD_BEEF);
    run_op(1'b1, 8'd8, 5'd31, 5'd0, 8'h5A, 0);
    chk("R8 full-width write", mem[8], 32'h0000_005A);
    chk("R8 full-width latency", 32'(n_cyc), 32'd8);
  endtask

  task automatic t_stall();
    load(2, 32'h0000_0F00);
    stall_set = stall_set + 3;
    run_op(1'b0, 8'd2, 5'd11, 5'd8, 8'h00, 0);
    chk("R6 stalled read value", 32'(r0v), 32'h0000_000F);
    chk("R6 stalled read latency", 32'(n_cyc), 32'd7);
    chk("R6 address held", 32'(addr_bad), 32'd0);
    load(4, 32'hA0A0_A0A0);
    stall_set = stall_set + 2;
    run_op(1'b1, 8'd4, 5'd3, 5'd0, 8'h09, 0);
    chk("R6 stalled write word", mem[4], 32'hA0A0_A0A9);
    chk("R6 stalled write latency", 32'(n_cyc), 32'd10);
  endtask

  task automatic t_invalid();
    run_op(1'b0, 8'd3, 5'd3, 5'd5, 8'h00, 0);
    chk("R7 read latency", 32'(n_cyc), 32'd2);
    chk("R7 no r0 write", 32'(seen_r0we), 32'd0);
    chk("R7 no bus request", 32'(req_seen), 32'd0);
    run_op(1'b1, 8'd7, 5'd2, 5'd6, 8'hFF, 0);
    chk("R7 write no request", 32'(req_seen), 32'd0);
    chk("R7 word unchanged", mem[7], 32'hFFFF_F5FF);
    run_op(1'b0, 8'd3, 5'd20, 5'd4, 8'h00, 0);
    chk("R8 17-bit read latency", 32'(n_cyc), 32'd2);
    chk("R8 17-bit read no r0", 32'(seen_r0we), 32'd0);
  endtask

  task automatic t_busy_poke();
    bit extra = 0;
    run_op(1'b0, 8'd3, 5'd7, 5'd4, 8'h00, 1);
    chk("R9 result kept", 32'(r0v), 32'h0000_000A);
    chk("R9 latency kept", 32'(n_cyc), 32'd4);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (done_o || bus_req_o) extra = 1;
    end
    chk("R9 no second access", 32'(extra || done_after), 32'd0);
    chk("R9 poked register intact", mem[5], 32'hBEEF_0000);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_read_basic();
    t_read_edges();
    t_write_basic();
    t_write_wide();
    t_stall();
    t_invalid();
    t_busy_poke();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule